// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the framing signals for a synchronous parallel display. It runs on the display interface clock and outputs horizontal sync, vertical sync, a data-enable, a once-per-pixel strobe and the coordinates of the current pixel. Every timing value comes from configuration inputs:

- **Horizontally:** the line length, the sync width, the leading blank and the active width.
- **Vertically:** the frame height, the sync width, the leading blank and the active height.
- **Pixel span:** the number of interface clocks that one pixel lasts.

A horizontal clock counter wraps at the end of each line. A line counter advances at every line wrap. Each output is decoded from these two counters against a shadow copy of the configuration. The shadow copy is refreshed only at a frame boundary. The horizontal sync width has half-clock resolution: a flop on the falling clock edge adds the extra half clock.

Configuration values are expected to satisfy these limits: both totals are at least 2, leading blank plus active width is less than the line length, and the horizontal sync width in half clocks is less than twice the line length.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, `hsync`, `vsync`, `de` and `pix_stb` are 0 and `pix_x`, `pix_y` are 0, whatever the polarity bits. The first rising clock edge after `rst` falls starts line 0, clock 0. The counters hold (0,0) for the whole of the following clock cycle, and the outputs decode that position in it.
- R2: A line lasts exactly `cfg_h_total` interface clocks, numbered 0 to `cfg_h_total`-1, after which the clock count returns to 0.
- R3: `cfg_h_sync` gives the hsync width in half clocks. Hsync is active from clock 0 of each line for floor(`cfg_h_sync`/2) whole clocks. When bit 0 of `cfg_h_sync` is 1, hsync stays active for a further first half of the next clock.
- R4: Horizontally, the active window covers clocks `cfg_h_lead` through `cfg_h_lead`+`cfg_h_active`-1 of a line. The clocks after it, up to the end of the line, are trailing blank.
- R5: A frame lasts `cfg_v_total` lines. Vsync is active for lines 0 through `cfg_v_sync`-1, so it changes only at clock 0 of a line.
- R6: Vertically, the active window covers lines `cfg_v_lead` through `cfg_v_lead`+`cfg_v_active`-1. The lines after it, up to the end of the frame, are trailing blank.
- R7: `de` is 1 exactly when the current clock lies in the horizontal window and the current line lies in the vertical window.
- R8: One pixel spans `cfg_clk_per_pix` clocks; a value of 0 counts as 1. The first pixel starts at the first active clock of the line. `pix_stb` is 1 on the first clock of each pixel while `de` is 1. `pix_x` is the pixel index counted from 0, it stays constant for all clocks of a pixel, and a last pixel may be cut short by the end of the window.
- R9: While `de` is 1, `pix_y` equals the line number minus `cfg_v_lead`. While `de` is 0, `pix_x` and `pix_y` are 0.
- R10: `cfg_hs_pol` = 1 makes `hsync` active-low, and `cfg_vs_pol` = 1 does the same for `vsync`. A value of 0 makes them active-high.
- R11: All configuration inputs are sampled only on the edge that starts a frame, and on every edge while the block is not yet running. A change in the middle of a frame has no effect on any output until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_total | input | 12 | Line length in clocks, blanking included |
| cfg_h_sync | input | 13 | Hsync width in half clocks |
| cfg_h_lead | input | 12 | Clocks of blank before the active pixels |
| cfg_h_active | input | 12 | Active clocks per line |
| cfg_v_total | input | 11 | Frame height in lines, blanking included |
| cfg_v_sync | input | 11 | Vsync width in lines |
| cfg_v_lead | input | 11 | Blank lines before the first active line |
| cfg_v_active | input | 11 | Active lines per frame |
| cfg_clk_per_pix | input | 3 | Clocks per pixel (0 counts as 1) |
| cfg_hs_pol | input | 1 | 1 = hsync active-low |
| cfg_vs_pol | input | 1 | 1 = vsync active-low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active data enable |
| pix_stb | output | 1 | First clock of each pixel |
| pix_x | output | 12 | Pixel index within the line |
| pix_y | output | 11 | Active line index |

## Verification
A wrong clock count shows up within one line as an hsync edge or a `de` window in the wrong clock. A wrong line count shows up at the next line wrap as a shifted vsync or `pix_y`. A stuck or overrunning pixel phase changes `pix_stb` spacing and `pix_x` on the second pixel of the first active line. A shadow copy loaded at the wrong moment alters outputs in the same frame, before the expected switch point at the frame boundary. The half-clock hsync tail exists only between a rising and a falling clock edge, so it is checked by sampling in both halves of the clock.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
  localparam int unsigned HW  = 12;   // horizontal count width
  localparam int unsigned VW  = 11;   // vertical count width
  localparam int unsigned CPW = 3;    // clocks-per-pixel width
  localparam int unsigned SPW = 16;   // common arithmetic width

  typedef logic [SPW-1:0] span_t;

  typedef struct packed {
    logic [HW-1:0]  h_total;
    logic [HW:0]    h_sync_half;
    logic [HW-1:0]  h_lead;
    logic [HW-1:0]  h_active;
    logic [VW-1:0]  v_total;
    logic [VW-1:0]  v_sync;
    logic [VW-1:0]  v_lead;
    logic [VW-1:0]  v_active;
    logic [CPW-1:0] clk_per_pix;
    logic           hs_low;
    logic           vs_low;
  } timing_t;

  // position c lies in [lead, lead+len)
  function automatic logic in_window(span_t c, span_t lead, span_t len);
    logic [SPW:0] stop;
    stop = {1'b0, lead} + {1'b0, len};
    return ({1'b0, c} >= {1'b0, lead}) && ({1'b0, c} < stop);
  endfunction

  function automatic logic [CPW-1:0] eff_cpp(logic [CPW-1:0] c);
    return (c == '0) ? CPW'(1) : c;
  endfunction

  // whole clocks of an hsync width given in half clocks
  function automatic span_t sync_full(span_t half);
    return half >> 1;
  endfunction

  function automatic logic is_last(span_t c, span_t total);
    return c == (total - span_t'(1));
  endfunction
endpackage

// File: rtl/raster_cfg_shadow.sv
`timescale 1ns/1ps
module raster_cfg_shadow
  import raster_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  timing_t live,
  output timing_t held
);
  always_ff @(posedge clk) begin
    if (rst)       held <= live;
    else if (load) held <= live;
  end
endmodule

// File: rtl/raster_axis_ctr.sv
`timescale 1ns/1ps
module raster_axis_ctr
  import raster_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = is_last(span_t'(cnt), span_t'(total));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (step)    cnt <= last ? '0 : cnt + W'(1);
  end

  // R2 (and R5 for the line counter): the count never leaves its period
  assert_ctr_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    (run && total >= W'(2)) |-> (cnt < total));
endmodule

// File: rtl/raster_pix_phase.sv
`timescale 1ns/1ps
module raster_pix_phase
  import raster_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           h_in,
  input  logic           de,
  input  logic [CPW-1:0] cpp_cfg,
  output logic           pix_stb,
  output logic [HW-1:0]  pix_x
);
  logic [CPW-1:0] cpp;
  logic [CPW-1:0] phase_q;
  logic [HW-1:0]  idx_q;
  logic           pix_end;

  assign cpp     = eff_cpp(cpp_cfg);
  assign pix_end = (phase_q == cpp - CPW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || !h_in) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (pix_end) begin
      phase_q <= '0;
      idx_q   <= idx_q + HW'(1);
    end else begin
      phase_q <= phase_q + CPW'(1);
    end
  end

  assign pix_stb = de && (phase_q == '0);
  assign pix_x   = de ? idx_q : '0;

  assert_phase_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    h_in |-> (phase_q < cpp));
  assert_x_steady_in_pixel_R8: assert property (@(posedge clk) disable iff (rst)
    (de && !pix_stb && $past(de)) |-> (pix_x == $past(pix_x)));
endmodule

// File: rtl/raster_sync_shape.sv
`timescale 1ns/1ps
module raster_sync_shape
  import raster_pkg::*;
#(
  parameter bit HALF_STEP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [HW:0]   h_sync_half,
  input  logic [VW-1:0] v_sync,
  input  logic          hs_low,
  input  logic          vs_low,
  output logic          hsync,
  output logic          vsync
);
  span_t full;
  logic  hs_body;
  logic  hs_tail;
  logic  hs_act;
  logic  vs_act;

  assign full    = sync_full(span_t'(h_sync_half));
  assign hs_body = run && (span_t'(hcnt) < full);

  generate
    if (HALF_STEP) begin : g_half
      logic tail_c;
      logic tail_n;
      assign tail_c = run && h_sync_half[0] && (span_t'(hcnt) == full);
      always_ff @(negedge clk) begin
        if (rst) tail_n <= 1'b0;
        else     tail_n <= tail_c;
      end
      assign hs_tail = tail_c && !tail_n;
    end else begin : g_whole
      assign hs_tail = 1'b0;
    end
  endgenerate

  assign hs_act = hs_body || hs_tail;
  assign vs_act = run && (vcnt < v_sync);
  assign hsync  = run ? (hs_act ^ hs_low) : 1'b0;
  assign vsync  = run ? (vs_act ^ vs_low) : 1'b0;

  assert_hs_within_width_R3: assert property (@(posedge clk) disable iff (rst)
    hs_act |-> (span_t'(hcnt) <= full));
  assert_vs_starts_at_line_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_act) |-> (hcnt == '0));
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter bit HALF_STEP = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HW-1:0]  cfg_h_total,
  input  logic [HW:0]    cfg_h_sync,
  input  logic [HW-1:0]  cfg_h_lead,
  input  logic [HW-1:0]  cfg_h_active,
  input  logic [VW-1:0]  cfg_v_total,
  input  logic [VW-1:0]  cfg_v_sync,
  input  logic [VW-1:0]  cfg_v_lead,
  input  logic [VW-1:0]  cfg_v_active,
  input  logic [CPW-1:0] cfg_clk_per_pix,
  input  logic           cfg_hs_pol,
  input  logic           cfg_vs_pol,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic           pix_stb,
  output logic [HW-1:0]  pix_x,
  output logic [VW-1:0]  pix_y
);
  timing_t       live;
  timing_t       cur;
  logic          run_q;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_last;
  logic          v_last;
  logic          frame_end;
  logic          load;
  logic          h_in;
  logic          v_in;

  assign live = '{h_total: cfg_h_total, h_sync_half: cfg_h_sync,
                  h_lead: cfg_h_lead, h_active: cfg_h_active,
                  v_total: cfg_v_total, v_sync: cfg_v_sync,
                  v_lead: cfg_v_lead, v_active: cfg_v_active,
                  clk_per_pix: cfg_clk_per_pix,
                  hs_low: cfg_hs_pol, vs_low: cfg_vs_pol};

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  assign frame_end = run_q && h_last && v_last;
  assign load      = !run_q || frame_end;

  raster_cfg_shadow u_shadow (
    .clk(clk), .rst(rst), .load(load), .live(live), .held(cur));

  raster_axis_ctr #(.W(HW)) u_hctr (
    .clk(clk), .rst(rst), .run(run_q), .step(1'b1),
    .total(cur.h_total), .cnt(hcnt), .last(h_last));

  raster_axis_ctr #(.W(VW)) u_vctr (
    .clk(clk), .rst(rst), .run(run_q), .step(h_last),
    .total(cur.v_total), .cnt(vcnt), .last(v_last));

  assign h_in = in_window(span_t'(hcnt), span_t'(cur.h_lead), span_t'(cur.h_active));
  assign v_in = in_window(span_t'(vcnt), span_t'(cur.v_lead), span_t'(cur.v_active));
  assign de   = run_q && h_in && v_in;
  assign pix_y = de ? (vcnt - cur.v_lead) : '0;

  raster_pix_phase u_phase (
    .clk(clk), .rst(rst), .run(run_q), .h_in(h_in), .de(de),
    .cpp_cfg(cur.clk_per_pix), .pix_stb(pix_stb), .pix_x(pix_x));

  raster_sync_shape #(.HALF_STEP(HALF_STEP)) u_sync (
    .clk(clk), .rst(rst), .run(run_q), .hcnt(hcnt), .vcnt(vcnt),
    .h_sync_half(cur.h_sync_half), .v_sync(cur.v_sync),
    .hs_low(cur.hs_low), .vs_low(cur.vs_low),
    .hsync(hsync), .vsync(vsync));

  assert_cfg_only_at_frame_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur) |-> (hcnt == '0 && vcnt == '0));
  assert_y_inside_window_R9: assert property (@(posedge clk) disable iff (rst)
    de |-> (pix_y < cur.v_active));
  assert_x_inside_window_R8: assert property (@(posedge clk) disable iff (rst)
    de |-> (pix_x < cur.h_active));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!de && !pix_stb));
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  import raster_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  timing_t       cfg;
  logic          hsync, vsync, de, pix_stb;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst),
    .cfg_h_total(cfg.h_total), .cfg_h_sync(cfg.h_sync_half),
    .cfg_h_lead(cfg.h_lead), .cfg_h_active(cfg.h_active),
    .cfg_v_total(cfg.v_total), .cfg_v_sync(cfg.v_sync),
    .cfg_v_lead(cfg.v_lead), .cfg_v_active(cfg.v_active),
    .cfg_clk_per_pix(cfg.clk_per_pix),
    .cfg_hs_pol(cfg.hs_low), .cfg_vs_pol(cfg.vs_low),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_stb(pix_stb),
    .pix_x(pix_x), .pix_y(pix_y));

  typedef struct {
    int hs_e; int hs_l; int vs; int de; int stb; int x; int y;
  } exp_t;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic timing_t mk(int ht, int hs, int hl, int ha, int vt, int vs,
                                 int vl, int va, int cp, int hp, int vp);
    timing_t t;
    t.h_total = HW'(ht);   t.h_sync_half = (HW+1)'(hs);
    t.h_lead  = HW'(hl);   t.h_active    = HW'(ha);
    t.v_total = VW'(vt);   t.v_sync      = VW'(vs);
    t.v_lead  = VW'(vl);   t.v_active    = VW'(va);
    t.clk_per_pix = CPW'(cp);
    t.hs_low = hp[0];      t.vs_low = vp[0];
    return t;
  endfunction

  // expected outputs k clocks after line 0 clock 0 of a frame of config c
  function automatic exp_t model(timing_t c, int k);
    exp_t e;
    int ht = int'(c.h_total);
    int vt = int'(c.v_total);
    int h  = k % ht;
    int v  = (k / ht) % vt;
    int cp = (c.clk_per_pix == 0) ? 1 : int'(c.clk_per_pix);
    int full = int'(c.h_sync_half) / 2;
    int odd  = int'(c.h_sync_half) % 2;
    int hl = int'(c.h_lead);
    int vl = int'(c.v_lead);
    bit hin = (h >= hl) && (h < hl + int'(c.h_active));
    bit vin = (v >= vl) && (v < vl + int'(c.v_active));
    e.de   = int'(hin && vin);
    e.hs_e = int'(((h < full) || (odd == 1 && h == full)) ^ c.hs_low);
    e.hs_l = int'((h < full) ^ c.hs_low);
    e.vs   = int'((v < int'(c.v_sync)) ^ c.vs_low);
    e.stb  = (e.de == 1 && ((h - hl) % cp) == 0) ? 1 : 0;
    e.x    = (e.de == 1) ? (h - hl) / cp : 0;
    e.y    = (e.de == 1) ? v - vl : 0;
    return e;
  endfunction

  // reset, then compare every output each clock; config b replaces a at clock sw
  task automatic run_scn(string name, timing_t a, timing_t b, int n, int sw);
    int fa = int'(a.h_total) * int'(a.v_total);
    cfg = a;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk({name, " R1"}, "hsync in reset", int'(hsync), 0);
    chk({name, " R1"}, "vsync in reset", int'(vsync), 0);
    chk({name, " R1"}, "de in reset", int'(de), 0);
    chk({name, " R1"}, "stb/x/y in reset", int'(pix_stb) + int'(pix_x) + int'(pix_y), 0);
    rst = 1'b0;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      #1;
      e = (k < fa) ? model(a, k) : model(b, k - fa);
      chk({name, " R2,R3,R10"}, "hsync early half", int'(hsync), e.hs_e);
      chk({name, " R5,R10"},    "vsync", int'(vsync), e.vs);
      chk({name, " R4,R6,R7"},  "de", int'(de), e.de);
      chk({name, " R8"},        "pix_stb", int'(pix_stb), e.stb);
      chk({name, " R8,R9"},     "pix_x", int'(pix_x), e.x);
      chk({name, " R9"},        "pix_y", int'(pix_y), e.y);
      #2.5;
      chk({name, " R3"},        "hsync late half", int'(hsync), e.hs_l);
      if (k == sw) cfg = b;
      @(posedge clk);
    end
  endtask

  task automatic t_basic();
    timing_t c = mk(12, 4, 3, 6, 6, 2, 1, 3, 1, 0, 0);
    run_scn("basic", c, c, 150, -1);
  endtask

  task automatic t_wide_pixel_inverted();
    timing_t c = mk(20, 5, 4, 7, 5, 1, 2, 2, 3, 1, 1);
    run_scn("cpp3_pol", c, c, 210, -1);
  endtask

  task automatic t_zero_cpp_half_only();
    timing_t c = mk(9, 1, 0, 5, 4, 3, 0, 3, 0, 0, 0);
    run_scn("cpp0_halfsync", c, c, 80, -1);
  endtask

  task automatic t_midframe_switch();
    timing_t a = mk(12, 4, 3, 6, 6, 2, 1, 3, 1, 0, 0);
    timing_t b = mk(10, 3, 2, 5, 5, 1, 1, 2, 2, 1, 0);
    run_scn("cfg_switch_R11", a, b, 132, 20);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cfg = mk(12, 4, 3, 6, 6, 2, 1, 3, 1, 0, 0);
    t_basic();
    t_wide_pixel_inverted();
    t_zero_cpp_half_only();
    t_midframe_switch();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule